// File: doc/BRIEF.md
# SPI Status Flags and Mode-Fault Controller

This block keeps the status flags and the control register of a serial peripheral port. It also reacts to a master-contention fault. The block watches the slave-select input and the shifter's edge and done pulses. It also watches the CPU's register accesses. From these it tracks whether a byte transfer is under way. It flags a CPU write into the data register that arrives during a transfer. It flags a transfer-complete event. When another device pulls slave-select low while this port is set up as master, it records a mode fault. A mode fault switches the port off and drops it to slave mode in the same clock edge.

Every flag is sticky. Software clears a flag in two steps. First it reads the status register while the flag shows 1, which arms the flag. Then it makes a qualifying access: the data register for the completion and collision flags, or a write to the control register for the fault flag. A status read that finds the flag at 0 disarms it. The shifter, the bit-rate generator and the pad logic sit outside this block. It only receives `sck_edge` and `xfer_done` from the shifter, and it returns `tx_start`.

Register select `cpu_addr`: 0 is status, 1 is control, 2 is data, and 3 selects nothing. Control layout: bit 0 is port enable, bit 1 is master, bit 2 is interrupt enable and bit 3 is clock phase. Bits 7..4 are plain storage.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset, the status register and the control register both read 0x00, `irq` is 0 and no transfer is in progress.
- R2: A status read (`cpu_addr`=0) returns the completion flag in bit 7, the collision flag in bit 6 and the fault flag in bit 4. Bits 5 and 3..0 always read 0. A control read (`cpu_addr`=1) returns the stored control byte. A data read (`cpu_addr`=2) and the unused address 3 both return 0.
- R3: With enable and master both set, a data write while idle pulses `tx_start` and starts a transfer. The transfer ends on `xfer_done`. A data write while any transfer is in progress sets the collision flag on the next edge.
- R4: With enable=1, master=0 and phase=0, a transfer is in progress from the edge after slave-select falls until the edge after it rises.
- R5: With enable=1, master=0 and phase=1, a transfer is in progress from the edge after the first `sck_edge` seen with slave-select low. It ends on the edge after `xfer_done`. Pulling slave-select low alone starts nothing.
- R6: The completion and collision flags clear only after two accesses in order. The first is a status read that saw the flag at 1. The second is a read or write of the data register. A data access without that prior read leaves the flag set.
- R7: With master=1 and slave-select low at a clock edge, the fault flag sets. At the same edge the enable and master bits go to 0.
- R8: `irq` is 1 exactly while interrupt enable is 1 and either the completion flag or the fault flag is 1.
- R9: The fault flag clears when the control register is written after a status read that saw the fault flag at 1. That control write is stored in full.
- R10: A control write made while the fault flag is set and not armed stores every bit except enable and master, which stay 0. The fault flag also stays set.
- R11: An `xfer_done` pulse sets the completion flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_n | input | 1 | Slave-select input, active low, already synchronous |
| sck_edge | input | 1 | One-cycle pulse from the shifter per active serial clock edge |
| xfer_done | input | 1 | One-cycle pulse from the shifter when a byte completes |
| cpu_addr | input | 2 | Register select: 0 status, 1 control, 2 data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the selected register, combinational |
| ctl_en | output | 1 | Port enable bit |
| ctl_mstr | output | 1 | Master mode bit |
| ctl_cpha | output | 1 | Clock phase bit |
| irq | output | 1 | Interrupt request |
| tx_start | output | 1 | Pulse asking the shifter to start a master transfer |
| xfer_busy | output | 1 | A transfer is in progress |

## Verification
`cpu_rdata` and `tx_start` are combinational, so they are due in the same cycle as the address and strobe that select them. Flag, control, busy and `irq` results land on the first rising edge after the stimulus, with one register stage and no more. The bench applies each stimulus just after a falling edge. It compares the combinational outputs one time unit later, then lets exactly one rising edge pass. Its reference model steps once per edge, so every compare falls in the cycle where the result is due. The directed checks read the registers back one cycle after each event, and a result that arrives early or late fails the compare.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_DATA   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_MSTR = 1;
  localparam int CB_IEN  = 2;
  localparam int CB_CPHA = 3;

  // status bit positions
  localparam int SB_DONE = 7;
  localparam int SB_WCOL = 6;
  localparam int SB_MODF = 4;

  // sticky flags cleared by data access
  localparam int NSTK    = 2;
  localparam int FI_DONE = 0;
  localparam int FI_WCOL = 1;

  function automatic logic [DW-1:0] pack_status(input logic done, input logic wcol,
                                                input logic modf);
    logic [DW-1:0] s;
    s          = '0;
    s[SB_DONE] = done;
    s[SB_WCOL] = wcol;
    s[SB_MODF] = modf;
    return s;
  endfunction

  function automatic logic [DW-1:0] ctl_next(input logic [DW-1:0] cur, input logic wr,
                                             input logic [DW-1:0] wd, input logic hold_off,
                                             input logic fault);
    logic [DW-1:0] n;
    n = cur;
    if (wr) begin
      n = wd;
      if (hold_off) begin
        n[CB_EN]   = 1'b0;
        n[CB_MSTR] = 1'b0;
      end
    end
    if (fault) begin
      n[CB_EN]   = 1'b0;
      n[CB_MSTR] = 1'b0;
    end
    return n;
  endfunction
endpackage

// File: rtl/spi_xfer_tracker.sv
module spi_xfer_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mstr,
  input  logic cpha,
  input  logic ss_n,
  input  logic sck_edge,
  input  logic xfer_done,
  input  logic data_wr,
  output logic busy,
  output logic tx_start
);
  logic ss_q;
  logic ss_fall, ss_rise;
  logic busy_d;

  assign ss_fall  = ss_q & ~ss_n;
  assign ss_rise  = ~ss_q & ss_n;
  assign tx_start = data_wr & en & mstr & ~busy;

  always_comb begin
    busy_d = busy;
    if (!en)
      busy_d = 1'b0;
    else if (mstr) begin
      if (xfer_done)     busy_d = 1'b0;
      else if (tx_start) busy_d = 1'b1;
    end else if (!cpha) begin
      if (ss_rise)      busy_d = 1'b0;
      else if (ss_fall) busy_d = 1'b1;
    end else begin
      if (xfer_done)               busy_d = 1'b0;
      else if (!ss_n && sck_edge)  busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_q <= 1'b1;
      busy <= 1'b0;
    end else begin
      ss_q <= ss_n;
      busy <= busy_d;
    end
  end
endmodule

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic sts_rd,
  input  logic clr_acc,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (sts_rd)       armed <= flag;
      else if (clr_acc) armed <= 1'b0;
      if (set)                          flag <= 1'b1;
      else if (clr_acc && armed && flag) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_fault_ctl.sv
module spi_fault_ctl
  import spi_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_n,
  input  logic          sts_rd,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] ctl_q,
  output logic          modf,
  output logic          fault
);
  logic armed;
  logic restore_ok;

  assign fault      = ctl_q[CB_MSTR] & ~ss_n;
  assign restore_ok = ~modf | armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      modf  <= 1'b0;
      armed <= 1'b0;
    end else begin
      ctl_q <= ctl_next(ctl_q, ctl_wr, wd, ~restore_ok, fault);
      if (sts_rd)      armed <= modf;
      else if (ctl_wr) armed <= 1'b0;
      if (fault)                        modf <= 1'b1;
      else if (ctl_wr && armed && modf) modf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_n,
  input  logic          sck_edge,
  input  logic          xfer_done,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          ctl_en,
  output logic          ctl_mstr,
  output logic          ctl_cpha,
  output logic          irq,
  output logic          tx_start,
  output logic          xfer_busy
);
  // named bus events
  logic sts_rd, data_acc, data_wr, ctl_wr;
  assign sts_rd   = cpu_rd & (cpu_addr == REG_STATUS);
  assign data_acc = (cpu_rd | cpu_wr) & (cpu_addr == REG_DATA);
  assign data_wr  = cpu_wr & (cpu_addr == REG_DATA);
  assign ctl_wr   = cpu_wr & (cpu_addr == REG_CTRL);

  logic [DW-1:0] ctl_q;
  logic          flag_modf, fault;
  logic          ctl_ien;

  spi_fault_ctl u_fault (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sts_rd(sts_rd), .ctl_wr(ctl_wr),
    .wd(cpu_wdata), .ctl_q(ctl_q), .modf(flag_modf), .fault(fault)
  );

  assign ctl_en   = ctl_q[CB_EN];
  assign ctl_mstr = ctl_q[CB_MSTR];
  assign ctl_cpha = ctl_q[CB_CPHA];
  assign ctl_ien  = ctl_q[CB_IEN];

  spi_xfer_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .mstr(ctl_mstr), .cpha(ctl_cpha),
    .ss_n(ss_n), .sck_edge(sck_edge), .xfer_done(xfer_done), .data_wr(data_wr),
    .busy(xfer_busy), .tx_start(tx_start)
  );

  logic [NSTK-1:0] set_v, flag_v;
  assign set_v[FI_DONE] = xfer_done;
  assign set_v[FI_WCOL] = data_wr & xfer_busy;

  for (genvar i = 0; i < NSTK; i++) begin : g_stk
    spi_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_v[i]), .sts_rd(sts_rd),
      .clr_acc(data_acc), .flag(flag_v[i])
    );
  end

  logic flag_done, flag_wcol;
  assign flag_done = flag_v[FI_DONE];
  assign flag_wcol = flag_v[FI_WCOL];

  assign irq = ctl_ien & (flag_done | flag_modf);

  always_comb begin
    unique case (cpu_addr)
      REG_STATUS: cpu_rdata = pack_status(flag_done, flag_wcol, flag_modf);
      REG_CTRL:   cpu_rdata = ctl_q;
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_flag_unit_chk.sv
module spi_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ss_n,
  input logic [1:0] cpu_addr,
  input logic [7:0] cpu_rdata,
  input logic       ctl_en,
  input logic       ctl_mstr,
  input logic       ctl_ien,
  input logic       irq,
  input logic       xfer_busy,
  input logic       flag_wcol,
  input logic       flag_modf,
  input logic       data_wr,
  input logic       data_acc,
  input logic       ctl_wr
);
  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == 2'd0) |-> ((cpu_rdata & 8'h2F) == 8'h00));

  assert_wcol_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_wcol) |-> $past(data_wr && xfer_busy));

  assert_wcol_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_wcol) |-> $past(data_acc));

  assert_modf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_modf) |-> $past(ctl_mstr && !ss_n));

  assert_fault_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_modf) |-> (!ctl_en && !ctl_mstr));

  assert_fault_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_modf) && ctl_ien) |-> irq);

  assert_modf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_modf) |-> $past(ctl_wr));

  assert_no_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_modf |-> (!ctl_en && !ctl_mstr));
endmodule

bind spi_flag_unit spi_flag_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
  .ctl_en(ctl_en), .ctl_mstr(ctl_mstr), .ctl_ien(ctl_ien), .irq(irq),
  .xfer_busy(xfer_busy), .flag_wcol(flag_wcol), .flag_modf(flag_modf),
  .data_wr(data_wr), .data_acc(data_acc), .ctl_wr(ctl_wr)
);

// File: tb/spi_flag_unit_tb_top.sv
module spi_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sck_edge = 1'b0, xfer_done = 1'b0;
  logic [1:0] cpu_addr = 2'd3;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic ctl_en, ctl_mstr, ctl_cpha, irq, tx_start, xfer_busy;

  always #4 clk = ~clk;

  spi_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck_edge(sck_edge), .xfer_done(xfer_done),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ctl_en(ctl_en), .ctl_mstr(ctl_mstr), .ctl_cpha(ctl_cpha),
    .irq(irq), .tx_start(tx_start), .xfer_busy(xfer_busy)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_done, m_wcol, m_modf, a_done, a_wcol, a_modf, m_busy, m_ssq;
  bit [7:0] m_ctl;
  // last sampled outputs
  bit [7:0] seen_rd;
  bit seen_irq, seen_busy, seen_tx, seen_en, seen_ms;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit [1:0] a, input bit r, input bit w, input bit [7:0] d,
                     input bit s, input bit k, input bit dn);
    bit [7:0] erd, nc;
    bit etx, en, ms, cp, sts, dacc, dwr, cwr, flt, nb, nd, nw, nm;
    cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    ss_n = s; sck_edge = k; xfer_done = dn;
    #1;
    en = m_ctl[0]; ms = m_ctl[1]; cp = m_ctl[3];
    sts = r && a == 0; dacc = (r || w) && a == 2; dwr = w && a == 2; cwr = w && a == 1;
    erd = (a == 0) ? {m_done, m_wcol, 1'b0, m_modf, 4'b0000} : (a == 1) ? m_ctl : 8'h00;
    etx = dwr && en && ms && !m_busy;
    seen_rd = cpu_rdata; seen_irq = irq; seen_busy = xfer_busy; seen_tx = tx_start;
    seen_en = ctl_en; seen_ms = ctl_mstr;
    chk(cpu_rdata === erd, "R2 readback", cpu_rdata, erd);
    chk(irq === (m_ctl[2] && (m_done || m_modf)), "R8 irq", irq, m_ctl[2] && (m_done || m_modf));
    chk({ctl_en, ctl_mstr, ctl_cpha} === {en, ms, cp}, "R7 control outputs",
        {ctl_en, ctl_mstr, ctl_cpha}, {en, ms, cp});
    chk(xfer_busy === m_busy, "R4 busy", xfer_busy, m_busy);
    chk(tx_start === etx, "R3 tx_start", tx_start, etx);
    // next state of the reference
    flt = ms && !s;
    if (!en) nb = 0;
    else if (ms) nb = dn ? 0 : (etx ? 1 : m_busy);
    else if (!cp) nb = (!m_ssq && s) ? 0 : ((m_ssq && !s) ? 1 : m_busy);
    else nb = dn ? 0 : ((!s && k) ? 1 : m_busy);
    nd = dn ? 1 : ((dacc && a_done && m_done) ? 0 : m_done);
    nw = (dwr && m_busy) ? 1 : ((dacc && a_wcol && m_wcol) ? 0 : m_wcol);
    nm = flt ? 1 : ((cwr && a_modf && m_modf) ? 0 : m_modf);
    nc = m_ctl;
    if (cwr) begin
      nc = d;
      if (m_modf && !a_modf) nc[1:0] = 2'b00;
    end
    if (flt) nc[1:0] = 2'b00;
    if (sts) begin a_done = m_done; a_wcol = m_wcol; a_modf = m_modf; end
    else begin
      if (dacc) begin a_done = 0; a_wcol = 0; end
      if (cwr) a_modf = 0;
    end
    m_done = nd; m_wcol = nw; m_modf = nm; m_ctl = nc; m_busy = nb; m_ssq = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input bit s);           cyc(2'd3, 0, 0, 8'h00, s, 0, 0); endtask
  task automatic rd(input bit [1:0] a, input bit s);  cyc(a, 1, 0, 8'h00, s, 0, 0); endtask
  task automatic wr(input bit [1:0] a, input bit [7:0] d, input bit s); cyc(a, 0, 1, d, s, 0, 0); endtask

  initial begin
    #1600000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    m_ssq = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, 1); chk(seen_rd == 8'h00, "R1 status after reset", seen_rd, 8'h00);
    chk(seen_irq == 0 && seen_busy == 0, "R1 irq/busy after reset", {seen_irq, seen_busy}, 0);
    rd(2'd1, 1); chk(seen_rd == 8'h00, "R1 control after reset", seen_rd, 8'h00);
    // R11 completion flag, R2 position
    cyc(2'd3, 0, 0, 8'h00, 1, 0, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h80, "R11 done sets bit7", seen_rd, 8'h80);
    rd(2'd2, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h00, "R6 read-then-data clears", seen_rd, 8'h00);
    // R6 data access without arming read
    cyc(2'd3, 0, 0, 8'h00, 1, 0, 1);
    wr(2'd2, 8'h11, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h80, "R6 unarmed access keeps flag", seen_rd, 8'h80);
    rd(2'd2, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h00, "R6 armed clear", seen_rd, 8'h00);
    // R3 master transfer and collision
    wr(2'd1, 8'h07, 1);
    wr(2'd2, 8'h55, 1); chk(seen_tx == 1, "R3 start pulse", seen_tx, 1);
    idle(1);            chk(seen_busy == 1, "R3 master busy", seen_busy, 1);
    wr(2'd2, 8'hAA, 1); chk(seen_tx == 0, "R3 no restart while busy", seen_tx, 0);
    rd(2'd0, 1); chk(seen_rd == 8'h40, "R3 collision flag", seen_rd, 8'h40);
    cyc(2'd3, 0, 0, 8'h00, 1, 0, 1);
    idle(1); chk(seen_irq == 1 && seen_busy == 0, "R8 irq from done", {seen_irq, seen_busy}, 2'b10);
    rd(2'd0, 1); chk(seen_rd == 8'hC0, "R2 both flags", seen_rd, 8'hC0);
    rd(2'd2, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h00, "R6 both cleared", seen_rd, 8'h00);
    // R7 mode fault
    idle(0);
    idle(1); chk(seen_en == 0 && seen_ms == 0, "R7 fault drops en/mstr", {seen_en, seen_ms}, 0);
    chk(seen_irq == 1, "R8 irq from fault", seen_irq, 1);
    // R10 write without arming
    wr(2'd1, 8'h07, 1);
    rd(2'd1, 1); chk(seen_rd == 8'h04, "R10 en/mstr held off", seen_rd, 8'h04);
    rd(2'd0, 1); chk(seen_rd == 8'h10, "R10 fault still set", seen_rd, 8'h10);
    // R9 clear sequence
    wr(2'd1, 8'hA7, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h00, "R9 fault cleared", seen_rd, 8'h00);
    rd(2'd1, 1); chk(seen_rd == 8'hA7, "R9 write stored in full", seen_rd, 8'hA7);
    // R4 slave phase 0
    wr(2'd1, 8'h01, 1);
    idle(0); chk(seen_busy == 0, "R4 not yet busy", seen_busy, 0);
    idle(0); chk(seen_busy == 1, "R4 busy after ss fall", seen_busy, 1);
    wr(2'd2, 8'h33, 0);
    idle(1);
    idle(1); chk(seen_busy == 0, "R4 idle after ss rise", seen_busy, 0);
    rd(2'd0, 1); chk(seen_rd == 8'h40, "R4 collision in slave", seen_rd, 8'h40);
    rd(2'd2, 1);
    wr(2'd2, 8'h44, 1);
    rd(2'd0, 1); chk(seen_rd == 8'h00, "R4 idle write no collision", seen_rd, 8'h00);
    // R5 slave phase 1
    wr(2'd1, 8'h09, 1);
    idle(0);
    idle(0); chk(seen_busy == 0, "R5 ss low alone", seen_busy, 0);
    wr(2'd2, 8'h01, 0);
    cyc(2'd3, 0, 0, 8'h00, 0, 1, 0);
    idle(0); chk(seen_busy == 1, "R5 busy after sck edge", seen_busy, 1);
    wr(2'd2, 8'h02, 0);
    cyc(2'd3, 0, 0, 8'h00, 0, 0, 1);
    idle(0); chk(seen_busy == 0, "R5 done ends transfer", seen_busy, 0);
    rd(2'd0, 0); chk(seen_rd == 8'hC0, "R5 flags after phase1", seen_rd, 8'hC0);
    idle(1);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule